// File: doc/BRIEF.md
# Register-Window AES-128 Block Cipher Engine

This block encrypts and decrypts single 128-bit blocks with AES-128. It is controlled through a narrow byte-wide register window that a serial slave front end drives. The window has three parts: a status byte, a control byte (with an alias at the top of the window), and a sixteen-byte data area. In key mode, writes to the data area fill a 128-bit key register. In the other modes, they fill the input block. Reads of the data area always return the last result. The engine only reads the key register, so one key can serve any number of operations.

Software writes the key, selects the mode and direction, writes sixteen input bytes, and then sets the start bit. It polls the done flag and reads sixteen result bytes. The data area has separate input and result storage at the same addresses. This means one burst can write the next input bytes while it reads back the previous result bytes, which shortens back-to-back ECB runs. CBC chaining is supported for encryption.

Top module: `aes_sec_engine`

## Requirements
- R1: After reset, the status byte, the control byte and every data-window byte read 0x00.
- R2: The status byte is at 0x82 and the control byte is at 0x83, with an alias at 0x94. Control fields: bit 7 is the start bit and always reads 0. Bits 5:4 are the mode (00 ECB, 01 key load, 10 CBC, 11 reserved). Bit 3 is the direction (1 = decrypt). Other bits read 0. Addresses outside 0x82..0x94 read 0x00, and writes to the status byte have no effect.
- R3: In key-load mode, a write to 0x84+i sets key byte i, where byte 0 is the first byte of the AES byte sequence. The key is never readable: data-window reads return the result buffer in every mode.
- R4: An ECB or CBC encryption produces the AES-128 ciphertext. Done reads 1 after the 10th rising edge that follows the edge accepting the start write, and reads 0 after the 9th.
- R5: An ECB decryption produces the AES-128 plaintext. Done reads 1 after the 20th rising edge that follows the start edge, and reads 0 after the 19th.
- R6: Status bit 0 (done) clears on the edge that accepts a legal start. The key register is never altered by an operation, so repeating an operation gives the same result.
- R7: A start request in key-load mode, in reserved mode, or in CBC with decrypt selected sets status bit 7 and launches nothing. Done and the result buffer are left unchanged. The next legal start clears bit 7.
- R8: While an operation runs, writes to the data window and to the control byte are ignored.
- R9: In CBC, each block is XORed with the previous CBC ciphertext before encryption. The chaining value is zero after reset.
- R10: A control write with the start bit at 0 resets the chaining value to zero. A control write that starts an operation keeps the chaining value.
- R11: When a data-window byte is written and read in the same cycle, the read returns the previous result byte and the write stores the new input byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Write strobe for the byte at addr |
| addr | input | ADDR_W | Byte address into the register window |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr (combinational) |

## Verification
A corrupted round key or state register changes the whole result block, so a single comparison against the standard test vectors catches it as soon as done rises. A wrong step counter shows up as done rising one edge early or late. A chaining value that is stale or wrongly cleared alters the second CBC block at its first read. A key register that an operation has overwritten makes the next repeated encryption differ from the first one.

// File: rtl/aes_sec_pkg.sv
package aes_sec_pkg;

  localparam int BLOCK_BITS = 128;
  localparam int BLOCK_BYTES = BLOCK_BITS / 8;

  typedef enum logic [1:0] {
    MODE_ECB = 2'b00,
    MODE_KEY = 2'b01,
    MODE_CBC = 2'b10,
    MODE_RSV = 2'b11
  } mode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       encLoad;
    logic       decPrep;
    logic       keyStep;
    logic       decLoad;
    logic       encRound;
    logic       decRound;
    logic       chainClr;
    logic       lastRound;
    logic       chainXor;
    logic [7:0] rcon;
  } aes_strobe_t;

  function automatic logic [7:0] xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, aa;
    p = 8'h00;
    aa = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ aa;
      aa = xtime(aa);
    end
    return p;
  endfunction

  // multiplicative inverse as a^254
  function automatic logic [7:0] ginv(input logic [7:0] a);
    logic [7:0] x2, x3, x6, x7, x14, x15, x30, x31, x62, x63, x126, x127;
    x2 = gmul(a, a);     x3 = gmul(x2, a);
    x6 = gmul(x3, x3);   x7 = gmul(x6, a);
    x14 = gmul(x7, x7);  x15 = gmul(x14, a);
    x30 = gmul(x15, x15); x31 = gmul(x30, a);
    x62 = gmul(x31, x31); x63 = gmul(x62, a);
    x126 = gmul(x63, x63); x127 = gmul(x126, a);
    return gmul(x127, x127);
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] b, input int n);
    logic [15:0] w;
    w = {b, b} << n;
    return w[15:8];
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] a);
    logic [7:0] b;
    b = ginv(a);
    return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ 8'h63;
  endfunction

  function automatic logic [7:0] invSbox(input logic [7:0] a);
    return ginv(rotl8(a, 1) ^ rotl8(a, 3) ^ rotl8(a, 6) ^ 8'h05);
  endfunction

  function automatic logic [7:0] rconOf(input logic [3:0] idx);
    logic [7:0] r;
    r = 8'h01;
    for (int i = 1; i < 10; i++) if (i < int'(idx)) r = xtime(r);
    return r;
  endfunction

  function automatic logic [127:0] subBytes(input logic [127:0] s, input logic inv);
    logic [127:0] o;
    for (int i = 0; i < 16; i++)
      o[127-8*i -: 8] = inv ? invSbox(s[127-8*i -: 8]) : sbox(s[127-8*i -: 8]);
    return o;
  endfunction

  function automatic logic [127:0] shiftRows(input logic [127:0] s, input logic inv);
    logic [127:0] o;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++) begin
        if (inv) o[127-8*(r+4*((c+r)%4)) -: 8] = s[127-8*(r+4*c) -: 8];
        else     o[127-8*(r+4*c) -: 8] = s[127-8*(r+4*((c+r)%4)) -: 8];
      end
    return o;
  endfunction

  function automatic logic [127:0] mixColumns(input logic [127:0] s);
    logic [127:0] o;
    logic [7:0] a0, a1, a2, a3;
    for (int c = 0; c < 4; c++) begin
      a0 = s[127-32*c -: 8]; a1 = s[119-32*c -: 8];
      a2 = s[111-32*c -: 8]; a3 = s[103-32*c -: 8];
      o[127-32*c -: 8] = xtime(a0) ^ xtime(a1) ^ a1 ^ a2 ^ a3;
      o[119-32*c -: 8] = a0 ^ xtime(a1) ^ xtime(a2) ^ a2 ^ a3;
      o[111-32*c -: 8] = a0 ^ a1 ^ xtime(a2) ^ xtime(a3) ^ a3;
      o[103-32*c -: 8] = xtime(a0) ^ a0 ^ a1 ^ a2 ^ xtime(a3);
    end
    return o;
  endfunction

  function automatic logic [127:0] invMixColumns(input logic [127:0] s);
    logic [127:0] o;
    logic [7:0] a0, a1, a2, a3;
    for (int c = 0; c < 4; c++) begin
      a0 = s[127-32*c -: 8]; a1 = s[119-32*c -: 8];
      a2 = s[111-32*c -: 8]; a3 = s[103-32*c -: 8];
      o[127-32*c -: 8] = gmul(a0, 8'h0e) ^ gmul(a1, 8'h0b) ^ gmul(a2, 8'h0d) ^ gmul(a3, 8'h09);
      o[119-32*c -: 8] = gmul(a0, 8'h09) ^ gmul(a1, 8'h0e) ^ gmul(a2, 8'h0b) ^ gmul(a3, 8'h0d);
      o[111-32*c -: 8] = gmul(a0, 8'h0d) ^ gmul(a1, 8'h09) ^ gmul(a2, 8'h0e) ^ gmul(a3, 8'h0b);
      o[103-32*c -: 8] = gmul(a0, 8'h0b) ^ gmul(a1, 8'h0d) ^ gmul(a2, 8'h09) ^ gmul(a3, 8'h0e);
    end
    return o;
  endfunction

  function automatic logic [31:0] schedWord(input logic [31:0] w, input logic [7:0] rc);
    logic [31:0] rot;
    rot = {w[23:0], w[31:24]};
    return {sbox(rot[31:24]) ^ rc, sbox(rot[23:16]), sbox(rot[15:8]), sbox(rot[7:0])};
  endfunction

  function automatic logic [127:0] keyForward(input logic [127:0] k, input logic [7:0] rc);
    logic [31:0] n0, n1, n2, n3;
    n0 = k[127:96] ^ schedWord(k[31:0], rc);
    n1 = k[95:64] ^ n0;
    n2 = k[63:32] ^ n1;
    n3 = k[31:0] ^ n2;
    return {n0, n1, n2, n3};
  endfunction

  function automatic logic [127:0] keyBackward(input logic [127:0] k, input logic [7:0] rc);
    logic [31:0] p0, p1, p2, p3;
    p3 = k[31:0] ^ k[63:32];
    p2 = k[63:32] ^ k[95:64];
    p1 = k[95:64] ^ k[127:96];
    p0 = k[127:96] ^ schedWord(p3, rc);
    return {p0, p1, p2, p3};
  endfunction

endpackage

// File: rtl/aes_sec_datapath.sv
module aes_sec_datapath
  import aes_sec_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  aes_strobe_t           strb,
  input  logic [BLOCK_BITS-1:0] keyVal,
  input  logic [BLOCK_BITS-1:0] inVal,
  output logic [BLOCK_BITS-1:0] resultVal
);

  logic [BLOCK_BITS-1:0] stateR, roundKeyR, chainR, resultR;
  logic [BLOCK_BITS-1:0] keyNext, keyPrev, encOut, decOut, encMid, decMid;

  always_comb begin
    keyNext = keyForward(roundKeyR, strb.rcon);
    keyPrev = keyBackward(roundKeyR, strb.rcon);
    encMid  = shiftRows(subBytes(stateR, 1'b0), 1'b0);
    encOut  = (strb.lastRound ? encMid : mixColumns(encMid)) ^ keyNext;
    decMid  = subBytes(shiftRows(stateR, 1'b1), 1'b1) ^ keyPrev;
    decOut  = strb.lastRound ? decMid : invMixColumns(decMid);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateR    <= '0;
      roundKeyR <= '0;
      chainR    <= '0;
      resultR   <= '0;
    end else begin
      if (strb.encLoad) begin
        stateR    <= inVal ^ keyVal ^ (strb.chainXor ? chainR : '0);
        roundKeyR <= keyVal;
      end
      if (strb.decPrep) roundKeyR <= keyVal;
      if (strb.keyStep) roundKeyR <= keyNext;
      if (strb.decLoad) begin
        roundKeyR <= keyNext;
        stateR    <= inVal ^ keyNext;
      end
      if (strb.encRound) begin
        roundKeyR <= keyNext;
        stateR    <= encOut;
        if (strb.lastRound) begin
          resultR <= encOut;
          if (strb.chainXor) chainR <= encOut;
        end
      end
      if (strb.decRound) begin
        roundKeyR <= keyPrev;
        stateR    <= decOut;
        if (strb.lastRound) resultR <= decOut;
      end
      if (strb.chainClr) chainR <= '0;
    end
  end

  assign resultVal = resultR;

endmodule

// File: rtl/aes_sec_ctrl.sv
module aes_sec_ctrl
  import aes_sec_pkg::*;
#(
  parameter int                ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR  = 'h82,
  parameter logic [ADDR_W-1:0] CTRL_ADDR  = 'h83,
  parameter logic [ADDR_W-1:0] DATA_BASE  = 'h84,
  parameter logic [ADDR_W-1:0] CTRL_ALIAS = 'h94,
  parameter int                NUM_ROUNDS = 10
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [7:0]            wdata,
  output logic [7:0]            rdata,
  input  logic [BLOCK_BITS-1:0] resultVal,
  output logic [BLOCK_BITS-1:0] keyVal,
  output logic [BLOCK_BITS-1:0] inVal,
  output logic                  busy,
  output logic                  doneFlag,
  output logic                  errFlag,
  output aes_strobe_t           strb
);

  localparam int IDX_W = $clog2(BLOCK_BYTES);
  localparam logic [3:0] LAST_CNT = 4'(NUM_ROUNDS);

  typedef enum logic [1:0] {PH_IDLE, PH_ENC, PH_DPREP, PH_DEC} phase_e;

  phase_e      phase;
  logic [3:0]  cnt;
  mode_e       modeR;
  logic        dirR;
  logic [BLOCK_BITS-1:0] keyR, inR;

  logic [ADDR_W-1:0] dataOff;
  logic [IDX_W-1:0]  idx;
  logic isStat, isCtrl, isData, idleWr, ctrlWr, startReq, legal, startOk;
  mode_e wMode;
  logic unusedBits;

  assign unusedBits = ^{wdata[6], wdata[2:0]};

  always_comb begin
    dataOff  = addr - DATA_BASE;
    idx      = dataOff[IDX_W-1:0];
    isStat   = (addr == STAT_ADDR);
    isCtrl   = (addr == CTRL_ADDR) || (addr == CTRL_ALIAS);
    isData   = dataOff < ADDR_W'(BLOCK_BYTES);
    busy     = (phase != PH_IDLE);
    idleWr   = wrEn && !busy;
    ctrlWr   = idleWr && isCtrl;
    wMode    = mode_e'(wdata[5:4]);
    startReq = ctrlWr && wdata[7];
    legal    = (wMode == MODE_ECB) || ((wMode == MODE_CBC) && !wdata[3]);
    startOk  = startReq && legal;
  end

  // strobe generation
  always_comb begin
    strb           = '0;
    strb.rcon      = rconOf(cnt);
    strb.chainXor  = busy ? (modeR == MODE_CBC) : (wMode == MODE_CBC);
    strb.chainClr  = ctrlWr && !wdata[7];
    strb.encLoad   = startOk && !wdata[3];
    strb.decPrep   = startOk && wdata[3];
    unique case (phase)
      PH_ENC: begin
        strb.encRound  = 1'b1;
        strb.lastRound = (cnt == LAST_CNT);
      end
      PH_DPREP: begin
        strb.keyStep = (cnt != LAST_CNT);
        strb.decLoad = (cnt == LAST_CNT);
      end
      PH_DEC: begin
        strb.decRound  = 1'b1;
        strb.lastRound = (cnt == 4'd1);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      modeR    <= MODE_ECB;
      dirR     <= 1'b0;
      doneFlag <= 1'b0;
      errFlag  <= 1'b0;
      keyR     <= '0;
      inR      <= '0;
    end else begin
      if (ctrlWr) begin
        modeR <= wMode;
        dirR  <= wdata[3];
      end
      if (startReq && !legal) errFlag <= 1'b1;
      if (startOk) begin
        errFlag  <= 1'b0;
        doneFlag <= 1'b0;
        cnt      <= 4'd1;
        phase    <= wdata[3] ? PH_DPREP : PH_ENC;
      end
      if (idleWr && isData) begin
        if (modeR == MODE_KEY) keyR[BLOCK_BITS-1-8*idx -: 8] <= wdata;
        else                   inR[BLOCK_BITS-1-8*idx -: 8]  <= wdata;
      end
      unique case (phase)
        PH_ENC: begin
          if (cnt == LAST_CNT) begin
            phase    <= PH_IDLE;
            doneFlag <= 1'b1;
          end else cnt <= cnt + 4'd1;
        end
        PH_DPREP: begin
          if (cnt == LAST_CNT) phase <= PH_DEC;
          else cnt <= cnt + 4'd1;
        end
        PH_DEC: begin
          if (cnt == 4'd1) begin
            phase    <= PH_IDLE;
            doneFlag <= 1'b1;
          end else cnt <= cnt - 4'd1;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (isStat)      rdata = {errFlag, 6'b0, doneFlag};
    else if (isCtrl) rdata = {2'b00, modeR, dirR, 3'b000};
    else if (isData) rdata = resultVal[BLOCK_BITS-1-8*idx -: 8];
  end

  assign keyVal = keyR;
  assign inVal  = inR;

endmodule

// File: rtl/aes_sec_engine.sv
module aes_sec_engine
  import aes_sec_pkg::*;
#(
  parameter int                ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR  = 'h82,
  parameter logic [ADDR_W-1:0] CTRL_ADDR  = 'h83,
  parameter logic [ADDR_W-1:0] DATA_BASE  = 'h84,
  parameter logic [ADDR_W-1:0] CTRL_ALIAS = 'h94
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);

  aes_strobe_t           strb;
  logic [BLOCK_BITS-1:0] keyVal, inVal, resultVal;
  logic                  busy, doneFlag, errFlag;

  aes_sec_ctrl #(
    .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .CTRL_ADDR(CTRL_ADDR),
    .DATA_BASE(DATA_BASE), .CTRL_ALIAS(CTRL_ALIAS), .NUM_ROUNDS(10)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wdata(wdata),
    .rdata(rdata), .resultVal(resultVal), .keyVal(keyVal), .inVal(inVal),
    .busy(busy), .doneFlag(doneFlag), .errFlag(errFlag), .strb(strb)
  );

  aes_sec_datapath dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .keyVal(keyVal), .inVal(inVal),
    .resultVal(resultVal)
  );

endmodule

// File: rtl/aes_sec_engine_chk.sv
module aes_sec_engine_chk
  import aes_sec_pkg::*;
(
  input logic                  clk,
  input logic                  rstN,
  input logic                  busy,
  input logic                  doneFlag,
  input logic                  errFlag,
  input logic [BLOCK_BITS-1:0] keyVal,
  input logic [BLOCK_BITS-1:0] inVal,
  input aes_strobe_t           strb
);

  a_r6_key_untouched_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(keyVal));

  a_r8_input_frozen_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(inVal));

  a_r6_done_low_on_launch: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !doneFlag);

  a_r4_done_at_finish: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> doneFlag);

  a_r7_error_no_launch: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> !busy);

  a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.encLoad, strb.decPrep, strb.keyStep, strb.decLoad,
              strb.encRound, strb.decRound, strb.chainClr}));

  a_r4_last_round_ends: assert property (@(posedge clk) disable iff (!rstN)
    strb.lastRound |=> !busy);

  a_r4_rcon_live: assert property (@(posedge clk) disable iff (!rstN)
    (strb.encRound || strb.keyStep || strb.decLoad || strb.decRound) |-> (strb.rcon != 8'h00));

  a_r9_cbc_encrypt_only: assert property (@(posedge clk) disable iff (!rstN)
    (busy && strb.chainXor) |-> !(strb.decRound || strb.keyStep || strb.decLoad));

endmodule

bind aes_sec_engine aes_sec_engine_chk chk_i (
  .clk(clk), .rstN(rstN), .busy(busy), .doneFlag(doneFlag), .errFlag(errFlag),
  .keyVal(keyVal), .inVal(inVal), .strb(strb)
);

// File: tb/tb_aes_sec_engine.sv
`timescale 1ns/1ps
module tb_aes_sec_engine;

  localparam logic [127:0] KB = 128'h2b7e151628aed2a6abf7158809cf4f3c;
  localparam logic [127:0] PB = 128'h3243f6a8885a308d313198a2e0370734;
  localparam logic [127:0] CB = 128'h3925841d02dc09fbdc118597196a0b32;
  localparam logic [127:0] KC = 128'h000102030405060708090a0b0c0d0e0f;
  localparam logic [127:0] PC = 128'h00112233445566778899aabbccddeeff;
  localparam logic [127:0] CC = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0;
  logic [7:0] addr = 8'h00, wdata = 8'h00, rdata;
  int testsRun = 0, testsFailed = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  aes_sec_engine dut (.clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wdata(wdata), .rdata(rdata));

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic check128(input string req, input logic [127:0] act, input logic [127:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: got %032h expected %032h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic writeBlock(input logic [127:0] b);
    for (int i = 0; i < 16; i++) wr(8'h84 + 8'(i), b[127-8*i -: 8]);
  endtask

  task automatic readBlock(output logic [127:0] b);
    logic [7:0] v;
    for (int i = 0; i < 16; i++) begin
      rd(8'h84 + 8'(i), v);
      b[127-8*i -: 8] = v;
    end
  endtask

  task automatic loadKey(input logic [127:0] k);
    wr(8'h83, 8'h10);
    writeBlock(k);
  endtask

  task automatic waitDone();
    logic [7:0] s;
    for (int i = 0; i < 64; i++) begin
      rd(8'h82, s);
      if (s[0]) break;
      @(posedge clk);
    end
  endtask

  task automatic checkTiming(input string req, input int edges);
    logic [7:0] s;
    repeat (edges - 1) @(posedge clk);
    rd(8'h82, s);
    check8({req, " done low one edge early"}, s & 8'h01, 8'h00);
    @(posedge clk);
    rd(8'h82, s);
    check8({req, " done high on time"}, s & 8'h01, 8'h01);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    logic [127:0] b;
    rd(8'h82, v); check8("R1 status", v, 8'h00);
    rd(8'h83, v); check8("R1 control", v, 8'h00);
    readBlock(b); check128("R1 result", b, '0);
    rd(8'h81, v); check8("R2 below window", v, 8'h00);
    rd(8'h95, v); check8("R2 above window", v, 8'h00);
    wr(8'h94, 8'h28);
    rd(8'h83, v); check8("R2 alias write", v, 8'h28);
    rd(8'h94, v); check8("R2 alias read", v, 8'h28);
    wr(8'h82, 8'hff);
    rd(8'h82, v); check8("R2 status write ignored", v, 8'h00);
  endtask

  task automatic t_enc_b();
    logic [7:0] v;
    logic [127:0] b;
    loadKey(KB);
    rd(8'h84, v); check8("R3 key not readable", v, 8'h00);
    wr(8'h83, 8'h00);
    writeBlock(PB);
    wr(8'h83, 8'h80);
    checkTiming("R4", 10);
    readBlock(b); check128("R4 ECB encrypt vector B", b, CB);
  endtask

  task automatic t_enc_c();
    logic [127:0] b;
    loadKey(KC);
    wr(8'h83, 8'h00);
    writeBlock(PC);
    wr(8'h83, 8'h80);
    waitDone();
    readBlock(b); check128("R3 R4 ECB encrypt vector C", b, CC);
  endtask

  task automatic t_dec_c();
    logic [127:0] b;
    wr(8'h83, 8'h08);
    writeBlock(CC);
    wr(8'h83, 8'h88);
    checkTiming("R5", 20);
    readBlock(b); check128("R5 ECB decrypt vector C", b, PC);
  endtask

  task automatic t_key_kept();
    logic [7:0] v;
    logic [127:0] b;
    wr(8'h83, 8'h00);
    writeBlock(PC);
    wr(8'h83, 8'h80);
    rd(8'h82, v); check8("R6 done cleared at start", v, 8'h00);
    waitDone();
    readBlock(b); check128("R6 key unchanged after ops", b, CC);
  endtask

  task automatic t_errors();
    logic [7:0] v;
    logic [127:0] b;
    wr(8'h83, 8'h90);
    rd(8'h82, v); check8("R7 start in key mode", v, 8'h81);
    readBlock(b); check128("R7 result unchanged", b, CC);
    wr(8'h83, 8'ha8);
    rd(8'h82, v); check8("R7 CBC decrypt start", v, 8'h81);
    wr(8'h83, 8'hb0);
    rd(8'h82, v); check8("R7 reserved mode start", v, 8'h81);
    wr(8'h83, 8'h00);
    wr(8'h83, 8'h80);
    waitDone();
    rd(8'h82, v); check8("R7 legal start clears error", v, 8'h01);
    readBlock(b); check128("R7 legal op result", b, CC);
  endtask

  task automatic t_busy();
    logic [7:0] v;
    logic [127:0] b;
    wr(8'h83, 8'h80);
    wr(8'h84, 8'haa);
    wr(8'h94, 8'h10);
    waitDone();
    rd(8'h83, v); check8("R8 control write ignored while busy", v, 8'h00);
    wr(8'h83, 8'h80);
    waitDone();
    readBlock(b); check128("R8 data write ignored while busy", b, CC);
  endtask

  task automatic t_cbc();
    logic [127:0] b;
    wr(8'h83, 8'h20);
    writeBlock(PC);
    wr(8'h83, 8'ha0);
    waitDone();
    readBlock(b); check128("R9 first CBC block uses zero chain", b, CC);
    writeBlock(PC ^ CC);
    wr(8'h83, 8'ha0);
    waitDone();
    readBlock(b); check128("R9 R10 second block chained", b, CC);
    wr(8'h83, 8'h20);
    writeBlock(PC);
    wr(8'h83, 8'ha0);
    waitDone();
    readBlock(b); check128("R10 chain reset by control write", b, CC);
  endtask

  task automatic t_fast();
    logic [127:0] b;
    int bad;
    loadKey(KB);
    wr(8'h83, 8'h00);
    bad = 0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      addr = 8'h84 + 8'(i); wdata = PB[127-8*i -: 8]; wrEn = 1'b1;
      #1;
      if (rdata !== CC[127-8*i -: 8]) begin
        bad++;
        $display("FAIL R11 byte %0d: got %02h expected %02h", i, rdata, CC[127-8*i -: 8]);
      end
    end
    @(negedge clk);
    wrEn = 1'b0;
    testsRun++;
    if (bad != 0) testsFailed++;
    wr(8'h83, 8'h80);
    waitDone();
    readBlock(b); check128("R11 burst stored new input", b, CB);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_enc_b();
    t_enc_c();
    t_dec_c();
    t_key_kept();
    t_errors();
    t_busy();
    t_cbc();
    t_fast();
    finishRun();
  end

endmodule